// File: doc/BRIEF.md
# Remote action service engine

This block sits beside a receiving processor and carries out cross-processor maintenance actions (translation invalidations of several kinds and model-register writes) entirely in hardware. It needs no interrupt handler. A sender places an action description in a shared in-memory table and marks the matching byte of this receiver's status vector as pending. It then delivers a request pulse through an interrupt-command style delivery mode. Because no software runs on the receiver, servicing goes ahead whatever the receiver's interrupt mask is and while a long operation is in progress.

On each accepted pulse the engine walks the status vector from slot 0 upwards. For every slot that reads pending, it first marks the slot taken, then fetches the first 32 bytes of the matching table entry and checks the action kind against its capability set. Next it hands a command to the downstream execution port and waits for completion. Finally it writes back a success or failure code. A pulse that lands during a walk is remembered, and it causes exactly one further walk once the current one ends.

Top module: `remote_action_engine`

## Requirements
- R1: After reset, mem_req and cmd_valid are low, and caps_info equals the SUPPORT parameter, whose bit k set means action kind k is supported.
- R2: A request pulse while cfg_enable is high starts a walk over slots 0 to N_SLOTS-1 in ascending order. Slot j's status is the byte at the vector base (low 6 bits ignored) plus j. Only slots holding 0x01 (pending) are written, and pending slots are serviced in ascending slot order.
- R3: For a pending slot, the byte 0x02 (taken) is written before any read of that slot's payload. The payload of slot j lies at the table base (low 12 bits ignored) plus 64*j. Within it, byte 0 is the kind, byte 1 the subtype, bytes 8-15 the identifier, bytes 16-23 the address or data word and bytes 24-31 the page count. All other payload bytes have no effect.
- R4: A supported kind produces one command whose cmd_type, cmd_subtype, cmd_id, cmd_arg and cmd_count are the payload fields. The command stays valid and stable until cmd_done. On a done without cmd_err, the slot's status becomes 0x00 (success).
- R5: A done with cmd_err high sets the slot's status to 0x80 (failure).
- R6: A kind of 6 or above, or a kind 0-5 whose SUPPORT bit is clear, issues no command and sets the status to 0x80.
- R7: One or more pulses arriving during a walk cause exactly one more full walk after the current one, so a slot made pending behind the walk's position is still serviced.
- R8: While cfg_enable is low, pulses are discarded, and an idle engine makes no memory access.
- R9: A memory request holds its address and direction until mem_ack. Reads are 8-byte aligned words. A write enables exactly one byte lane, carries the status byte replicated across all lanes, and only ever carries 0x00, 0x02 or 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Feature enable |
| cfg_tbl_base | input | AW | Payload table base address (4 KB aligned) |
| cfg_vec_base | input | AW | Status vector base address (64 B aligned) |
| caps_info | output | 8 | Supported action kinds, one bit per kind |
| req_pulse | input | 1 | One-cycle request indication from the delivery path |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, 8-byte aligned |
| mem_be | output | 8 | Byte lane enables for writes (all ones on reads) |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed; read data valid in this cycle |
| mem_rdata | input | 64 | Read data |
| cmd_valid | output | 1 | Downstream command present |
| cmd_type | output | 3 | Action kind |
| cmd_subtype | output | 8 | Kind refinement |
| cmd_id | output | 64 | Context identifier or register index |
| cmd_arg | output | 64 | Start address or register data |
| cmd_count | output | 64 | Page count |
| cmd_done | input | 1 | Command completed (one cycle) |
| cmd_err | input | 1 | Completion reports an error (with cmd_done) |

## Verification
The walk is exercised with a single pending slot, with slots scattered at both ends and in the middle, and with neighbours holding every non-pending code. Together these separate ordering, slot-to-address mapping and the untouched-slot rule. Payloads carry junk in unused bytes and distinct values in every field, so that a swapped or shifted field shows. Kind codes cover supported, reserved and supported-in-principle-but-masked cases, and the downstream error response is tried on its own. A pulse sent while a command is in flight, for a slot the walk has already passed, shows whether the request is remembered. A pulse with the enable low shows whether it is discarded.

// File: rtl/rae_pkg.sv
package rae_pkg;

   localparam int WORD_W    = 64;
   localparam int LANES     = WORD_W / 8;
   localparam int PL_WORDS  = 4;
   localparam int NUM_KINDS = 6;

   localparam logic [7:0] ST_OK    = 8'h00;
   localparam logic [7:0] ST_WAIT  = 8'h01;
   localparam logic [7:0] ST_TAKEN = 8'h02;
   localparam logic [7:0] ST_BAD   = 8'h80;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_RD_STAT,
      FS_WR_TAKEN,
      FS_RD_PL,
      FS_CHECK,
      FS_CMD,
      FS_WR_FINAL,
      FS_NEXT
   } fsm_t;

   typedef struct packed {
      logic [7:0]        kind;
      logic [7:0]        sub;
      logic [WORD_W-1:0] ident;
      logic [WORD_W-1:0] arg;
      logic [WORD_W-1:0] count;
   } payload_t;

endpackage

// File: rtl/rae_req_tracker.sv
module rae_req_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic req_pulse,
   input  logic enable,
   input  logic consume,
   output logic pend
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else
         pend_q <= (pend_q & ~consume) | (req_pulse & enable);
   end

   assign pend = pend_q;

endmodule

// File: rtl/rae_kind_gate.sv
module rae_kind_gate
   import rae_pkg::*;
#(
   parameter logic [7:0] SUPPORT = 8'h3F
) (
   input  logic [7:0] kind,
   output logic       kind_ok,
   output logic [7:0] caps
);

   logic [7:0] sup_vec;

   for (genvar k = 0; k < 8; k++) begin : g_kind
      if (k < NUM_KINDS) begin : g_defined
         assign sup_vec[k] = SUPPORT[k];
      end else begin : g_reserved
         assign sup_vec[k] = 1'b0;
      end
   end

   assign kind_ok = (kind[7:3] == 5'd0) && sup_vec[kind[2:0]];
   assign caps    = sup_vec;

endmodule

// File: rtl/rae_addr_gen.sv
module rae_addr_gen #(
   parameter int AW         = 32,
   parameter int N_SLOTS    = 64,
   parameter int SLOT_BYTES = 64,
   localparam int SW        = $clog2(N_SLOTS)
) (
   input  logic [AW-1:0] tbl_base,
   input  logic [AW-1:0] vec_base,
   input  logic [SW-1:0] slot,
   input  logic [1:0]    widx,
   output logic [AW-1:0] stat_addr,
   output logic [AW-1:0] pl_addr
);

   localparam int TBL_ALIGN = $clog2(N_SLOTS * SLOT_BYTES);
   localparam int VEC_ALIGN = 6;
   localparam int SLOT_SH   = $clog2(SLOT_BYTES);

   localparam logic [AW-1:0] TBL_MASK = ~((AW'(1) << TBL_ALIGN) - AW'(1));
   localparam logic [AW-1:0] VEC_MASK = ~((AW'(1) << VEC_ALIGN) - AW'(1));

   logic [AW-1:0] tbl_al, vec_al;

   assign tbl_al    = tbl_base & TBL_MASK;
   assign vec_al    = vec_base & VEC_MASK;
   assign stat_addr = vec_al | AW'(slot);
   assign pl_addr   = tbl_al | (AW'(slot) << SLOT_SH) | (AW'(widx) << 3);

endmodule

// File: rtl/rae_seq.sv
module rae_seq
   import rae_pkg::*;
#(
   parameter int AW      = 32,
   parameter int N_SLOTS = 64,
   localparam int SW     = $clog2(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend,
   output logic              consume,
   output logic              busy,
   output logic [SW-1:0]     slot,
   output logic [1:0]        widx,
   input  logic [AW-1:0]     stat_addr,
   input  logic [AW-1:0]     pl_addr,
   output payload_t          pl,
   input  logic              kind_ok,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_done,
   input  logic              cmd_err
);

   localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

   fsm_t       state;
   logic [7:0] result;
   logic [2:0] lane;
   logic [7:0] rd_byte;
   logic       last_slot;

   assign lane      = stat_addr[2:0];
   assign rd_byte   = mem_rdata[{lane, 3'b000} +: 8];
   assign last_slot = (slot == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FS_IDLE;
         slot   <= '0;
         widx   <= '0;
         pl     <= '0;
         result <= ST_OK;
      end else begin
         case (state)
            FS_IDLE: begin
               if (pend) begin
                  slot  <= '0;
                  state <= FS_RD_STAT;
               end
            end
            FS_RD_STAT: begin
               if (mem_ack)
                  state <= (rd_byte == ST_WAIT) ? FS_WR_TAKEN : FS_NEXT;
            end
            FS_WR_TAKEN: begin
               if (mem_ack) begin
                  widx  <= '0;
                  state <= FS_RD_PL;
               end
            end
            FS_RD_PL: begin
               if (mem_ack) begin
                  case (widx)
                     2'd0: begin
                        pl.kind <= mem_rdata[7:0];
                        pl.sub  <= mem_rdata[15:8];
                     end
                     2'd1:    pl.ident <= mem_rdata;
                     2'd2:    pl.arg   <= mem_rdata;
                     default: pl.count <= mem_rdata;
                  endcase
                  if (widx == 2'(PL_WORDS - 1))
                     state <= FS_CHECK;
                  else
                     widx <= widx + 2'd1;
               end
            end
            FS_CHECK: begin
               if (kind_ok)
                  state <= FS_CMD;
               else begin
                  result <= ST_BAD;
                  state  <= FS_WR_FINAL;
               end
            end
            FS_CMD: begin
               if (cmd_done) begin
                  result <= cmd_err ? ST_BAD : ST_OK;
                  state  <= FS_WR_FINAL;
               end
            end
            FS_WR_FINAL: begin
               if (mem_ack)
                  state <= FS_NEXT;
            end
            FS_NEXT: begin
               if (last_slot) begin
                  if (pend) begin
                     slot  <= '0;
                     state <= FS_RD_STAT;
                  end else begin
                     state <= FS_IDLE;
                  end
               end else begin
                  slot  <= slot + 1'b1;
                  state <= FS_RD_STAT;
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == FS_RD_STAT) || (state == FS_WR_TAKEN) ||
                  (state == FS_RD_PL)   || (state == FS_WR_FINAL);
      mem_we    = (state == FS_WR_TAKEN) || (state == FS_WR_FINAL);
      mem_addr  = (state == FS_RD_PL) ? pl_addr : {stat_addr[AW-1:3], 3'b000};
      mem_be    = mem_we ? (LANES'(1) << lane) : {LANES{1'b1}};
      mem_wdata = {LANES{(state == FS_WR_TAKEN) ? ST_TAKEN : result}};
      cmd_valid = (state == FS_CMD);
      busy      = (state != FS_IDLE);
      consume   = pend && ((state == FS_IDLE) || ((state == FS_NEXT) && last_slot));
   end

endmodule

// File: rtl/remote_action_engine.sv
module remote_action_engine
   import rae_pkg::*;
#(
   parameter int         AW         = 32,
   parameter int         N_SLOTS    = 64,
   parameter int         SLOT_BYTES = 64,
   parameter logic [7:0] SUPPORT    = 8'h3F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_enable,
   input  logic [AW-1:0] cfg_tbl_base,
   input  logic [AW-1:0] cfg_vec_base,
   output logic [7:0]    caps_info,
   input  logic          req_pulse,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_be,
   output logic [63:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [63:0]   mem_rdata,
   output logic          cmd_valid,
   output logic [2:0]    cmd_type,
   output logic [7:0]    cmd_subtype,
   output logic [63:0]   cmd_id,
   output logic [63:0]   cmd_arg,
   output logic [63:0]   cmd_count,
   input  logic          cmd_done,
   input  logic          cmd_err
);

   localparam int SW = $clog2(N_SLOTS);

   if (N_SLOTS < 2 || N_SLOTS > 64 || (N_SLOTS & (N_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("N_SLOTS must be a power of two between 2 and 64");
   end
   if (SLOT_BYTES < PL_WORDS * LANES || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_slot_bytes
      $error("SLOT_BYTES must be a power of two of at least 32");
   end
   if (AW < $clog2(N_SLOTS * SLOT_BYTES) + 1) begin : g_bad_aw
      $error("AW too narrow for the payload table");
   end
   if (SUPPORT[7:NUM_KINDS] != '0) begin : g_bad_support
      $error("SUPPORT may only mark kinds 0 to 5");
   end

   logic          pend, consume, busy, kind_ok;
   logic [SW-1:0] slot;
   logic [1:0]    widx;
   logic [AW-1:0] stat_addr, pl_addr;
   payload_t      pl;

   rae_req_tracker u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_pulse (req_pulse),
      .enable    (cfg_enable),
      .consume   (consume),
      .pend      (pend)
   );

   rae_kind_gate #(.SUPPORT(SUPPORT)) u_gate (
      .kind    (pl.kind),
      .kind_ok (kind_ok),
      .caps    (caps_info)
   );

   rae_addr_gen #(.AW(AW), .N_SLOTS(N_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_addr (
      .tbl_base  (cfg_tbl_base),
      .vec_base  (cfg_vec_base),
      .slot      (slot),
      .widx      (widx),
      .stat_addr (stat_addr),
      .pl_addr   (pl_addr)
   );

   rae_seq #(.AW(AW), .N_SLOTS(N_SLOTS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend),
      .consume   (consume),
      .busy      (busy),
      .slot      (slot),
      .widx      (widx),
      .stat_addr (stat_addr),
      .pl_addr   (pl_addr),
      .pl        (pl),
      .kind_ok   (kind_ok),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_be    (mem_be),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .cmd_valid (cmd_valid),
      .cmd_done  (cmd_done),
      .cmd_err   (cmd_err)
   );

   assign cmd_type    = pl.kind[2:0];
   assign cmd_subtype = pl.sub;
   assign cmd_id      = pl.ident;
   assign cmd_arg     = pl.arg;
   assign cmd_count   = pl.count;

endmodule

// File: rtl/rae_chk.sv
module rae_chk #(
   parameter int         AW      = 32,
   parameter logic [7:0] SUPPORT = 8'h3F
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_enable,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [7:0]    mem_be,
   input logic [63:0]   mem_wdata,
   input logic          mem_ack,
   input logic          cmd_valid,
   input logic          cmd_done,
   input logic [2:0]    cmd_type,
   input logic [63:0]   cmd_id,
   input logic          busy,
   input logic          pend
);

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> $countones(mem_be) == 1); // R9

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> (mem_wdata[7:0] == 8'h00 || mem_wdata[7:0] == 8'h02 ||
                             mem_wdata[7:0] == 8'h80)); // R9

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_id) && $stable(cmd_type)); // R4

   AST_CMD_KIND_OK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_type <= 3'd5) && SUPPORT[cmd_type]); // R6

   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !pend && !cfg_enable |=> !mem_req); // R8

endmodule

bind remote_action_engine rae_chk #(.AW(AW), .SUPPORT(SUPPORT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .cmd_valid  (cmd_valid),
   .cmd_done   (cmd_done),
   .cmd_type   (cmd_type),
   .cmd_id     (cmd_id),
   .busy       (busy),
   .pend       (pend)
);

// File: tb/sim_remote_action_engine.sv
`timescale 1ns/1ps
module sim_remote_action_engine;

   localparam int AW = 32;
   localparam logic [7:0] SUP = 8'h37;   // kind 3 masked off
   localparam logic [31:0] VEC_BASE = 32'h0000_0040;
   localparam logic [31:0] TBL_BASE = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0;
   logic          req_pulse = 1'b0;
   logic [7:0]    caps_info;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_be;
   logic [63:0]   mem_wdata;
   logic          mem_ack = 1'b0;
   logic [63:0]   mem_rdata = '0;
   logic          cmd_valid;
   logic [2:0]    cmd_type;
   logic [7:0]    cmd_subtype;
   logic [63:0]   cmd_id, cmd_arg, cmd_count;
   logic          cmd_done = 1'b0;
   logic          cmd_err = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   remote_action_engine #(.AW(AW), .SUPPORT(SUP)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .cfg_tbl_base(TBL_BASE | 32'h0000_0ABC), .cfg_vec_base(VEC_BASE | 32'h0000_0015),
      .caps_info(caps_info), .req_pulse(req_pulse),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_subtype(cmd_subtype),
      .cmd_id(cmd_id), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
      .cmd_done(cmd_done), .cmd_err(cmd_err)
   );

   // memory model: 8 KB, one-cycle acknowledge
   logic [63:0] mem [0:1023];
   int wlog_slot [0:1023];
   int wlog_val  [0:1023];
   int wlog_n = 0;
   int req_cycles = 0;
   int bad_addr = 0;
   int pl_read_before_taken = 0;
   logic [63:0] clog_id [0:255];
   logic [2:0]  clog_type [0:255];
   logic [7:0]  clog_sub [0:255];
   logic [63:0] clog_arg [0:255];
   logic [63:0] clog_cnt [0:255];
   int clog_n = 0;
   int cdly = 0;
   int taken_seen = -1;

   always @(posedge clk) begin
      if (mem_req) req_cycles <= req_cycles + 1;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_addr >= 32'h2000 || mem_addr[2:0] != 3'd0) bad_addr <= bad_addr + 1;
         if (mem_we) begin
            for (int b = 0; b < 8; b++) begin
               if (mem_be[b]) begin
                  mem[mem_addr[12:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
                  wlog_slot[wlog_n] <= (int'(mem_addr[12:3]) - 8) * 8 + b;
                  wlog_val[wlog_n]  <= int'(mem_wdata[8*b +: 8]);
                  if (mem_wdata[8*b +: 8] == 8'h02) taken_seen <= (int'(mem_addr[12:3]) - 8) * 8 + b;
               end
            end
            wlog_n <= wlog_n + 1;
         end else begin
            mem_rdata <= mem[mem_addr[12:3]];
            if (mem_addr >= TBL_BASE &&
                int'((mem_addr - TBL_BASE) >> 6) != taken_seen)
               pl_read_before_taken <= pl_read_before_taken + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // downstream responder: done two cycles after valid; error when id is 0xDEAD
   always @(posedge clk) begin
      if (cmd_done) begin
         cmd_done <= 1'b0;
         cmd_err  <= 1'b0;
      end else if (cmd_valid) begin
         if (cdly == 2) begin
            cdly <= 0;
            cmd_done <= 1'b1;
            cmd_err  <= (cmd_id == 64'hDEAD);
            clog_id[clog_n]   <= cmd_id;
            clog_type[clog_n] <= cmd_type;
            clog_sub[clog_n]  <= cmd_subtype;
            clog_arg[clog_n]  <= cmd_arg;
            clog_cnt[clog_n]  <= cmd_count;
            clog_n <= clog_n + 1;
         end else begin
            cdly <= cdly + 1;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] stat(input int j);
      return mem[8 + j/8][8*(j%8) +: 8];
   endfunction

   task automatic set_stat(input int j, input logic [7:0] v);
      mem[8 + j/8][8*(j%8) +: 8] = v;
   endtask

   task automatic set_pl(input int j, input logic [7:0] kind, input logic [7:0] sub,
                         input logic [63:0] id, input logic [63:0] arg, input logic [63:0] cnt);
      mem[512 + j*8 + 0] = {48'hA5A5_5A5A_C3C3, sub, kind};
      mem[512 + j*8 + 1] = id;
      mem[512 + j*8 + 2] = arg;
      mem[512 + j*8 + 3] = cnt;
      for (int w = 4; w < 8; w++) mem[512 + j*8 + w] = 64'hFFFF_0000_FFFF_0000;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = '0;
   endtask

   task automatic pulse();
      @(negedge clk) req_pulse = 1'b1;
      @(negedge clk) req_pulse = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      for (int i = 0; i < 4000 && q < 20; i++) begin
         @(negedge clk);
         if (mem_req || cmd_valid) q = 0; else q++;
      end
   endtask

   task automatic t_reset();
      chk("R1", "mem_req after reset", 64'(mem_req), 64'd0);
      chk("R1", "cmd_valid after reset", 64'(cmd_valid), 64'd0);
      chk("R1", "caps_info", 64'(caps_info), 64'(SUP));
   endtask

   task automatic t_single();
      int w0 = wlog_n;
      int c0 = clog_n;
      clear_mem();
      set_stat(5, 8'h01);
      set_stat(4, 8'h01);  set_stat(4, 8'h00);
      set_pl(5, 8'd4, 8'h3C, 64'h0000_0000_0000_0ABC, 64'h7000_1000_2000_3000, 64'd3);
      pulse();
      wait_quiet();
      chk("R4", "command count", 64'(clog_n - c0), 64'd1);
      chk("R4", "cmd_type", 64'(clog_type[c0]), 64'd4);
      chk("R3", "cmd_subtype from byte 1", 64'(clog_sub[c0]), 64'h3C);
      chk("R3", "cmd_id from bytes 8-15", clog_id[c0], 64'h0ABC);
      chk("R3", "cmd_arg from bytes 16-23", clog_arg[c0], 64'h7000_1000_2000_3000);
      chk("R3", "cmd_count from bytes 24-31", clog_cnt[c0], 64'd3);
      chk("R3", "first write is taken", 64'(wlog_val[w0]), 64'h02);
      chk("R3", "first write slot", 64'(wlog_slot[w0]), 64'd5);
      chk("R4", "final status success", 64'(stat(5)), 64'h00);
      chk("R2", "only two status writes", 64'(wlog_n - w0), 64'd2);
      chk("R3", "payload read only after taken", 64'(pl_read_before_taken), 64'd0);
   endtask

   task automatic t_order();
      int c0 = clog_n;
      clear_mem();
      set_stat(63, 8'h01); set_pl(63, 8'd2, 8'h00, 64'h63, 64'h0, 64'd1);
      set_stat(0,  8'h01); set_pl(0,  8'd0, 8'h01, 64'h00, 64'h1000, 64'd2);
      set_stat(17, 8'h01); set_pl(17, 8'd5, 8'h00, 64'h17, 64'hCAFE, 64'd0);
      pulse();
      wait_quiet();
      chk("R2", "ascending order first", clog_id[c0], 64'h00);
      chk("R2", "ascending order second", clog_id[c0 + 1], 64'h17);
      chk("R2", "ascending order third", clog_id[c0 + 2], 64'h63);
      chk("R4", "slot 63 success", 64'(stat(63)), 64'h00);
   endtask

   task automatic t_error();
      clear_mem();
      set_stat(9, 8'h01);
      set_pl(9, 8'd1, 8'h00, 64'hDEAD, 64'h0, 64'd1);
      pulse();
      wait_quiet();
      chk("R5", "downstream error gives failure", 64'(stat(9)), 64'h80);
   endtask

   task automatic t_kinds();
      int c0 = clog_n;
      clear_mem();
      set_stat(1, 8'h01); set_pl(1, 8'd6,   8'h00, 64'h01, 64'h0, 64'd0);
      set_stat(2, 8'h01); set_pl(2, 8'hC8,  8'h00, 64'h02, 64'h0, 64'd0);
      set_stat(3, 8'h01); set_pl(3, 8'd3,   8'h00, 64'h03, 64'h0, 64'd0);
      set_stat(4, 8'h01); set_pl(4, 8'd5,   8'h00, 64'h04, 64'h55, 64'd0);
      pulse();
      wait_quiet();
      chk("R6", "reserved kind 6 fails", 64'(stat(1)), 64'h80);
      chk("R6", "reserved kind 0xC8 fails", 64'(stat(2)), 64'h80);
      chk("R6", "masked kind 3 fails", 64'(stat(3)), 64'h80);
      chk("R6", "only the supported kind issued", 64'(clog_n - c0), 64'd1);
      chk("R6", "issued command is slot 4", clog_id[c0], 64'h04);
   endtask

   task automatic t_untouched();
      int w0 = wlog_n;
      clear_mem();
      set_stat(20, 8'h00); set_stat(21, 8'h02); set_stat(22, 8'h80); set_stat(23, 8'h07);
      set_stat(24, 8'h01); set_pl(24, 8'd4, 8'h00, 64'h24, 64'h0, 64'd1);
      pulse();
      wait_quiet();
      chk("R2", "slot 21 untouched", 64'(stat(21)), 64'h02);
      chk("R2", "slot 22 untouched", 64'(stat(22)), 64'h80);
      chk("R2", "slot 23 untouched", 64'(stat(23)), 64'h07);
      chk("R2", "writes only for pending slot", 64'(wlog_n - w0), 64'd2);
   endtask

   task automatic t_disabled();
      int r0;
      clear_mem();
      set_stat(3, 8'h01); set_pl(3, 8'd4, 8'h00, 64'h33, 64'h0, 64'd1);
      @(negedge clk) cfg_enable = 1'b0;
      repeat (4) @(negedge clk);
      r0 = req_cycles;
      pulse();
      repeat (40) @(negedge clk);
      chk("R8", "no memory access while disabled", 64'(req_cycles - r0), 64'd0);
      chk("R8", "pending slot left alone", 64'(stat(3)), 64'h01);
      @(negedge clk) cfg_enable = 1'b1;
      repeat (10) @(negedge clk);
      chk("R8", "discarded pulse not replayed", 64'(stat(3)), 64'h01);
      set_stat(3, 8'h00);
   endtask

   task automatic t_rescan();
      int c0 = clog_n;
      clear_mem();
      set_stat(50, 8'h01); set_pl(50, 8'd2, 8'h00, 64'h50, 64'h0, 64'd1);
      set_pl(10, 8'd0, 8'h00, 64'h10, 64'h4000, 64'd1);
      pulse();
      for (int i = 0; i < 2000 && !cmd_valid; i++) @(negedge clk);
      set_stat(10, 8'h01);
      pulse();
      pulse();
      wait_quiet();
      chk("R7", "two commands in total", 64'(clog_n - c0), 64'd2);
      chk("R7", "slot behind walk serviced second", clog_id[c0 + 1], 64'h10);
      chk("R7", "slot 10 success", 64'(stat(10)), 64'h00);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk) cfg_enable = 1'b1;
      t_single();
      t_order();
      t_error();
      t_kinds();
      t_untouched();
      t_disabled();
      t_rescan();
      chk("R9", "all accesses aligned and in range", 64'(bad_addr), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule